// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block keeps a free-running up-counter that advances once per microsecond. It runs from whatever reference clock the chip supplies, for example 12, 12.8, 13, 16.8, 19.2, 26, 38.4 or 48 MHz. A ratio register holds two 8-bit fields. Each field stores its value minus one, and together they set how many reference clocks make one microsecond. When that ratio is not a whole number, a fractional accumulator spreads the counter steps so that their average spacing is exact.

Software reaches the block through a simple register port: a write strobe, an address, write data and combinational read data. It can read the microsecond counter, program the ratio and stop the timebase with a hold bit. Each reference-clock edge is one accumulator step. The block does not generate any clock.

Top module: `ustb_top`

## Requirements
- R1: After reset the counter (offset 0x10) reads 0, the ratio register (offset 0x14) reads 0x0000000B and the hold register (offset 0x4C) reads 0.
- R2: The ratio register holds the step field s in bits 15:8 and the span field p in bits 7:0, each stored as value minus one. On every active clock the accumulator adds s+1 and the counter steps when the accumulator reaches p+1. After N active clocks from an accumulator clear, with s < p, the counter has risen by floor(N*(s+1)/(p+1)).
- R3: With ratio 0x000B the counter steps exactly once every 12 active clocks: it reads 2 after 30 clocks and 3 after 36.
- R4: With ratio 0x043F the counter steps 5 times in every 64 active clocks, an average of 12.8 clocks per step. The accumulator never exceeds p.
- R5: The counter steps at most once per clock. When s >= p it steps on every active clock, and any leftover above p is clipped to p.
- R6: The hold register is bit 0 at offset 0x4C. While it reads 1, neither the counter nor the accumulator changes. The clock edge that writes the hold bit still follows the old value.
- R7: A write to offset 0x14 loads bits 15:0 into the ratio register and clears the accumulator, but leaves the counter unchanged. That clock edge adds nothing to the accumulator. Bits 31:16 are ignored and read back as 0.
- R8: The counter is read-only: a write to offset 0x10 leaves its value unchanged.
- R9: The counter is CNT_W bits wide and wraps from all ones to zero.
- R10: Any other address reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each edge is one accumulator step |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register byte offset for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |

## Verification
The bound checker watches, on every cycle, the internal invariants: the accumulator never passes the span, the counter never moves by more than one, nothing moves while hold is set, and a ratio write leaves the accumulator empty with no step. The bench's scenarios show the rate behaviour, which no single-cycle property can: exact step counts over long windows for integer, fractional and clipped ratios, and the accumulator's remainder surviving a hold. Only the bench shows the port-level effects: the reset values, ignored writes to the counter and to unmapped addresses, zeroed upper ratio bits, and counter wrap. The wrap check uses a second, narrow instance.

// File: rtl/ustb_pkg.sv
package ustb_pkg;

    localparam int unsigned REG_ADDR_W = 8;
    localparam int unsigned FIELD_W    = 8;
    localparam int unsigned RATIO_W    = 2 * FIELD_W;
    localparam int unsigned ACC_W      = FIELD_W + 1;

    localparam logic [REG_ADDR_W-1:0] OFF_COUNT = 8'h10;
    localparam logic [REG_ADDR_W-1:0] OFF_RATIO = 8'h14;
    localparam logic [REG_ADDR_W-1:0] OFF_HOLD  = 8'h4C;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_RATIO,
        SEL_HOLD
    } reg_sel_e;

    // high field: amount added per clock (minus one); low field: span (minus one)
    typedef struct packed {
        logic [FIELD_W-1:0] step_m1;
        logic [FIELD_W-1:0] span_m1;
    } ratio_cfg_t;

    localparam ratio_cfg_t RATIO_RST = '{step_m1: '0, span_m1: FIELD_W'(11)};

    function automatic reg_sel_e decode_addr(input logic [REG_ADDR_W-1:0] a);
        reg_sel_e s;
        if (a == OFF_COUNT)      s = SEL_COUNT;
        else if (a == OFF_RATIO) s = SEL_RATIO;
        else if (a == OFF_HOLD)  s = SEL_HOLD;
        else                     s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [ACC_W-1:0] field_plus1(input logic [FIELD_W-1:0] f);
        return ACC_W'(f) + ACC_W'(1);
    endfunction

endpackage

// File: rtl/ustb_regs.sv
module ustb_regs
    import ustb_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output ratio_cfg_t            ratio,
    output logic                  ratio_load,
    output logic                  hold
);

    reg_sel_e sel;
    logic     unused_wdata;

    assign sel          = decode_addr(addr);
    assign ratio_load   = wr_en && (sel == SEL_RATIO);
    assign unused_wdata = ^wdata[DATA_W-1:RATIO_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio <= RATIO_RST;
            hold  <= 1'b0;
        end else if (wr_en) begin
            if (sel == SEL_RATIO) ratio <= ratio_cfg_t'(wdata[RATIO_W-1:0]);
            if (sel == SEL_HOLD)  hold  <= wdata[0];
        end
    end

endmodule

// File: rtl/ustb_accum.sv
module ustb_accum
    import ustb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ratio_cfg_t       ratio,
    input  logic             load,
    input  logic             hold,
    output logic             tick,
    output logic [ACC_W-1:0] acc
);

    logic [ACC_W-1:0] add_amt;
    logic [ACC_W-1:0] limit;
    logic [ACC_W-1:0] span_top;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] resid;
    logic [ACC_W-1:0] acc_nxt;

    assign add_amt  = field_plus1(ratio.step_m1);
    assign limit    = field_plus1(ratio.span_m1);
    assign span_top = ACC_W'(ratio.span_m1);
    assign sum      = acc + add_amt;
    assign resid    = sum - limit;

    always_comb begin
        tick    = 1'b0;
        acc_nxt = acc;
        if (load) begin
            acc_nxt = '0;
        end else if (!hold) begin
            if (sum >= limit) begin
                tick    = 1'b1;
                acc_nxt = (resid > span_top) ? span_top : resid;
            end else begin
                acc_nxt = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc_nxt;
    end

endmodule

// File: rtl/ustb_counter.sv
module ustb_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/ustb_rdmux.sv
module ustb_rdmux
    import ustb_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]      cnt,
    input  ratio_cfg_t            ratio,
    input  logic                  hold,
    output logic [DATA_W-1:0]     rdata
);

    reg_sel_e sel;
    assign sel = decode_addr(addr);

    always_comb begin
        case (sel)
            SEL_COUNT: rdata = DATA_W'(cnt);
            SEL_RATIO: rdata = DATA_W'(ratio);
            SEL_HOLD:  rdata = DATA_W'(hold);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/ustb_top.sv
module ustb_top
    import ustb_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata
);

    ratio_cfg_t       ratio_q;
    logic             ratio_load;
    logic             hold_q;
    logic             acc_tick;
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] count_q;

    ustb_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .ratio      (ratio_q),
        .ratio_load (ratio_load),
        .hold       (hold_q)
    );

    ustb_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .ratio (ratio_q),
        .load  (ratio_load),
        .hold  (hold_q),
        .tick  (acc_tick),
        .acc   (acc_q)
    );

    ustb_counter #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst  (rst),
        .tick (acc_tick),
        .cnt  (count_q)
    );

    ustb_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rdmux (
        .addr  (reg_addr),
        .cnt   (count_q),
        .ratio (ratio_q),
        .hold  (hold_q),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/ustb_chk.sv
module ustb_chk
    import ustb_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               hold,
    input logic               load,
    input logic [ACC_W-1:0]   acc,
    input logic [FIELD_W-1:0] span_m1,
    input logic [CNT_W-1:0]   cnt
);

    assert_acc_below_span_R4: assert property (@(posedge clk) disable iff (rst)
        acc <= ACC_W'(span_m1));

    assert_tick_steps_one_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == $past(cnt) + CNT_W'(1));

    assert_idle_keeps_count_R9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> cnt == $past(cnt));

    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        hold |-> !tick);

    assert_hold_freezes_acc_R6: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(acc));

    assert_load_clears_acc_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> acc == '0);

    assert_load_no_tick_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> !tick);

endmodule

bind ustb_top ustb_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (acc_tick),
    .hold    (hold_q),
    .load    (ratio_load),
    .acc     (acc_q),
    .span_m1 (ratio_q.span_m1),
    .cnt     (count_q)
);

// File: tb/tb_ustb_top.sv
module tb_ustb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] reg_rdata_w;

    always #10 clk = ~clk;

    ustb_top #(.CNT_W(32), .DATA_W(32)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    ustb_top #(.CNT_W(8), .DATA_W(32)) dut_w (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata_w)
    );

    typedef struct {
        string       tag;
        logic [31:0] exp;
        bit          narrow;
    } exp_t;

    exp_t   sb_q[$];
    event   mon_ev;
    int     n_tests = 0;
    int     n_fail  = 0;
    bit     done    = 1'b0;

    // reference model state
    longint base_cnt = 0;
    longint n_act    = 0;
    int     m_step   = 0;
    int     m_span   = 11;
    bit     m_hold   = 1'b0;

    function automatic longint exp_count();
        longint inc;
        if (m_step >= m_span) inc = n_act;
        else inc = (n_act * (m_step + 1)) / (m_span + 1);
        return base_cnt + inc;
    endfunction

    // monitor: pops expected items and compares against the port
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [31:0] got;
                it  = sb_q.pop_front();
                got = it.narrow ? reg_rdata_w : reg_rdata;
                n_tests++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic check_reg(input string tag, input logic [7:0] a,
                             input logic [31:0] e, input bit narrow);
        reg_addr = a;
        #2;
        sb_q.push_back('{tag: tag, exp: e, narrow: narrow});
        ->mon_ev;
        #1;
    endtask

    task automatic check_cnt(input string tag);
        longint e;
        e = exp_count();
        check_reg(tag, 8'h10, e[31:0], 1'b0);
        check_reg({tag, " narrow"}, 8'h10, {24'h0, e[7:0]}, 1'b1);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            if (!m_hold) n_act++;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a == 8'h14) begin
            base_cnt = exp_count();
            n_act    = 0;
            m_step   = int'(d[15:8]);
            m_span   = int'(d[7:0]);
        end else begin
            if (!m_hold) n_act++;
            if (a == 8'h4C) m_hold = d[0];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check_reg("R1 counter", 8'h10, 32'h0, 1'b0);
        check_reg("R1 ratio", 8'h14, 32'h0000000B, 1'b0);
        check_reg("R1 hold", 8'h4C, 32'h0, 1'b0);
        rst = 1'b0;

        // R3 integer ratio 12
        step(30);
        check_cnt("R3 30 clocks");
        step(6);
        check_cnt("R3 36 clocks");

        // R7 ratio write keeps counter; R2 field layout
        wr(8'h14, 32'h0000043F);
        check_reg("R2 ratio readback", 8'h14, 32'h0000043F, 1'b0);
        check_cnt("R7 counter kept");
        // R4 fractional 12.8
        step(63);
        check_cnt("R4 63 clocks");
        step(1);
        check_cnt("R4 64 clocks");
        step(13);
        check_cnt("R4 77 clocks");

        // R7 upper bits ignored
        wr(8'h14, 32'hABCD0004);
        check_reg("R7 upper bits zero", 8'h14, 32'h00000004, 1'b0);
        step(10);
        check_cnt("R2 ratio 5");

        // R8 counter write ignored
        wr(8'h10, 32'h12345678);
        check_cnt("R8 counter write");

        // R10 unmapped address
        wr(8'h20, 32'hFFFFFFFF);
        check_reg("R10 unmapped read", 8'h20, 32'h0, 1'b0);
        check_reg("R10 ratio untouched", 8'h14, 32'h00000004, 1'b0);
        check_reg("R10 hold untouched", 8'h4C, 32'h0, 1'b0);

        // R6 hold keeps counter and accumulator remainder
        wr(8'h14, 32'h0000000B);
        step(18);
        wr(8'h4C, 32'h00000001);
        check_reg("R6 hold readback", 8'h4C, 32'h1, 1'b0);
        check_cnt("R6 at hold");
        step(50);
        check_cnt("R6 held 50 clocks");
        wr(8'h4C, 32'h00000000);
        step(4);
        check_cnt("R6 remainder 23");
        step(1);
        check_cnt("R6 remainder 24");

        // R7 ratio write clears accumulator
        wr(8'h14, 32'h0000000B);
        step(11);
        wr(8'h14, 32'h0000000B);
        step(1);
        check_cnt("R7 accumulator cleared");
        step(11);
        check_cnt("R7 first step after clear");

        // R5 one step per clock, R9 wrap on narrow instance
        wr(8'h14, 32'h00000000);
        step(300);
        check_cnt("R5 R9 unit ratio wrap");
        wr(8'h14, 32'h00000500);
        step(10);
        check_cnt("R5 clipped ratio");

        // R2 another fraction 19.2
        wr(8'h14, 32'h0000045F);
        step(192);
        check_cnt("R2 ratio 19.2");
        step(100);
        check_cnt("R2 ratio 19.2 partial");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule